// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block decides when a small microcontroller core is held in reset and when it may run. It watches five inputs that can each start a reset or a wake-up: a power-on detect, an active-low external reset pin, a watchdog time-out pulse, a wake-up request and a HALT-state indication from the core. From these it drives two outputs. The first is a held full reset for the core. The second is a one-cycle warm-reset strobe, which clears only the program counter and the stack pointer.

After every reset or wake-up, a start-up timer holds the core for 1024 system clock cycles. This gives the oscillator time to settle before execution starts. The block also keeps two status flags, time-out (TO) and power-down (PD). Software reads them to tell which cause started the last sequence.

The held full reset is the common clear control for the rest of the chip. While it is high, the program counter is forced to zero, interrupts are disabled, the prescaler and watchdog are cleared, the timer/event counter is stopped, the I/O ports are in input mode and the stack pointer points to the top of the stack. The watchdog starts counting again once the full reset is released.

Top module: `wake_reset_seq`

## Requirements
- R1: While `por` is high, `core_rst` and `sst_busy` are 1 and TO=0, PD=0. Both outputs stay high for 1023 more cycles after the last clock edge that samples `por` high, and both fall in the cycle after that. `pc_sp_clr` is high whenever `core_rst` is high.
- R2: `ext_rst_n` passes through a two-flop synchroniser. A low level seen while the core is not halted gives `core_rst`=1 from the third clock edge after the pin falls, and it leaves TO and PD unchanged. The core stays in reset while the pin is low. `core_rst` and `sst_busy` fall 1026 cycles after the cycle in which the pin returns high.
- R3: An external reset that starts while `halted`=1 is a full reset, timed as in R2, and sets TO=0, PD=1.
- R4: A `wdt_timeout` pulse while not halted gives a full reset. It sets TO=1, leaves PD unchanged, and `core_rst` falls 1024 cycles after the edge that samples the pulse.
- R5: A `wdt_timeout` pulse while `halted`=1 (and no full reset is running) does not assert `core_rst`. It sets TO=1, PD=1 and holds `sst_busy`=1 for 1024 cycles. In the cycle after `sst_busy` falls, `warm_rst` and `pc_sp_clr` are 1 for exactly one cycle.
- R6: A `wake_req` while `halted`=1 and no sequence is running holds `sst_busy` for 1024 cycles. It asserts neither `core_rst` nor `warm_rst` and changes no flag. A `wake_req` while not halted has no effect.
- R7: A new cause that arrives during the start-up delay restarts the 1024-cycle count and updates the flags for the new cause. A watchdog time-out while halted does not turn a running full reset into a warm reset, and no `warm_rst` follows it.
- R8: `halt_exec`=1 in a cycle with no reset or wake cause sets TO=0, PD=1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on detect; synchronous active-high reset of the block |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| halted | input | 1 | Core is in HALT state |
| wake_req | input | 1 | Wake-up request from HALT |
| halt_exec | input | 1 | Halt instruction executes: TO cleared, PD set |
| core_rst | output | 1 | Held full reset of the core and its peripherals |
| warm_rst | output | 1 | One-cycle strobe clearing program counter and stack pointer |
| pc_sp_clr | output | 1 | Program counter and stack pointer clear (full or warm) |
| sst_busy | output | 1 | Start-up timer running |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
The assertions check, on every cycle, the rules that relate neighbouring cycles:
- the warm strobe lasts one cycle and never overlaps a full reset;
- a low synchronised pin forces the counter to zero under full reset;
- any cause restarts the count;
- the start-up delay ends only from the terminal count;
- a running full reset is never shortened to a warm reset;
- the flag updates follow the cause table.

Only the bench scenarios can show the absolute timing: the 1024-cycle delay length, the three-cycle synchroniser latency, the release 1026 cycles after the pin returns high, and the restarted delay length. The same holds for the flag values built up over a chain of causes and for a wake request being ignored when the core is running.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_FULL,
        MODE_WARM,
        MODE_WAKE
    } seq_mode_e;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_EXT_RUN,
        CAUSE_EXT_HALT,
        CAUSE_WDT_RUN,
        CAUSE_WDT_HALT,
        CAUSE_WAKE
    } cause_e;

    typedef struct packed {
        logic to;
        logic pd;
    } stat_flags_t;

    // Priority: pin edge, pin held low (masks all), watchdog, wake request
    function automatic cause_e pick_cause(logic ext_start, logic ext_low, logic wdt,
                                          logic halted, logic wake, logic idle);
        cause_e c;
        if (ext_start)                   c = halted ? CAUSE_EXT_HALT : CAUSE_EXT_RUN;
        else if (ext_low)                c = CAUSE_NONE;
        else if (wdt)                    c = halted ? CAUSE_WDT_HALT : CAUSE_WDT_RUN;
        else if (wake && halted && idle) c = CAUSE_WAKE;
        else                             c = CAUSE_NONE;
        return c;
    endfunction

    function automatic seq_mode_e next_mode(seq_mode_e cur, cause_e c);
        seq_mode_e m;
        case (c)
            CAUSE_EXT_RUN, CAUSE_EXT_HALT, CAUSE_WDT_RUN: m = MODE_FULL;
            CAUSE_WDT_HALT: m = (cur == MODE_FULL) ? MODE_FULL : MODE_WARM;
            CAUSE_WAKE:     m = MODE_WAKE;
            default:        m = cur;
        endcase
        return m;
    endfunction

    function automatic stat_flags_t flags_for(stat_flags_t cur, cause_e c);
        stat_flags_t f;
        f = cur;
        case (c)
            CAUSE_EXT_HALT: begin f.to = 1'b0; f.pd = 1'b1; end
            CAUSE_WDT_RUN:  f.to = 1'b1;
            CAUSE_WDT_HALT: begin f.to = 1'b1; f.pd = 1'b1; end
            default:        f = cur;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) shreg <= RST_VAL;
                else     shreg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) shreg <= {STAGES{RST_VAL}};
                else     shreg <= {shreg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/rstseq_sst.sv
module rstseq_sst #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    localparam logic [CNT_W-1:0] TERM = '1;

    always_ff @(posedge clk) begin
        if (rst)                  cnt <= '0;
        else if (restart || hold) cnt <= '0;
        else if (run)             cnt <= cnt + 1'b1;
    end

    assign done = run && !restart && !hold && (cnt == TERM);
endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cause_e      cause,
    input  logic        halt_exec,
    output stat_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst)                     flags <= '0;
        else if (cause != CAUSE_NONE) flags <= flags_for(flags, cause);
        else if (halt_exec)          flags <= '{to: 1'b0, pd: 1'b1};
    end

    AST_HALT_EXEC_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (halt_exec && cause == CAUSE_NONE) |=> (!flags.to && flags.pd)); // R8

    AST_WDT_SETS_TO: assert property (@(posedge clk) disable iff (rst)
        (cause == CAUSE_WDT_RUN || cause == CAUSE_WDT_HALT) |=> flags.to); // R4

    AST_WDT_RUN_KEEPS_PD: assert property (@(posedge clk) disable iff (rst)
        (cause == CAUSE_WDT_RUN) |=> (flags.pd == $past(flags.pd))); // R4

    AST_EXT_RUN_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (cause == CAUSE_EXT_RUN) |=> $stable(flags)); // R2

    AST_EXT_HALT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (cause == CAUSE_EXT_HALT) |=> (!flags.to && flags.pd)); // R3
endmodule

// File: rtl/wake_reset_seq.sv
module wake_reset_seq
    import rstseq_pkg::*;
#(
    parameter int SST_BITS    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic ext_rst_n,
    input  logic wdt_timeout,
    input  logic halted,
    input  logic wake_req,
    input  logic halt_exec,
    output logic core_rst,
    output logic warm_rst,
    output logic pc_sp_clr,
    output logic sst_busy,
    output logic to_flag,
    output logic pd_flag
);
    localparam logic [SST_BITS-1:0] TERM = '1;

    logic                pin_q;
    logic                ext_low;
    logic                ext_low_q;
    logic                ext_start;
    cause_e              cause;
    seq_mode_e           mode;
    logic [SST_BITS-1:0] cnt;
    logic                done;
    logic                warm_q;
    stat_flags_t         flags;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk (clk),
        .rst (por),
        .d   (ext_rst_n),
        .q   (pin_q)
    );

    assign ext_low   = !pin_q;
    assign ext_start = ext_low && !ext_low_q;
    assign cause     = pick_cause(ext_start, ext_low, wdt_timeout, halted,
                                  wake_req, mode == MODE_IDLE);

    rstseq_sst #(.CNT_W(SST_BITS)) i_sst (
        .clk     (clk),
        .rst     (por),
        .run     (mode != MODE_IDLE),
        .restart (cause != CAUSE_NONE),
        .hold    (ext_low),
        .cnt     (cnt),
        .done    (done)
    );

    rstseq_flags i_flags (
        .clk       (clk),
        .rst       (por),
        .cause     (cause),
        .halt_exec (halt_exec),
        .flags     (flags)
    );

    always_ff @(posedge clk) begin
        if (por) begin
            mode      <= MODE_FULL;
            ext_low_q <= 1'b0;
            warm_q    <= 1'b0;
        end else begin
            ext_low_q <= ext_low;
            warm_q    <= done && (mode == MODE_WARM);
            if (cause != CAUSE_NONE) mode <= next_mode(mode, cause);
            else if (done)           mode <= MODE_IDLE;
        end
    end

    assign core_rst  = (mode == MODE_FULL);
    assign sst_busy  = (mode != MODE_IDLE);
    assign warm_rst  = warm_q;
    assign pc_sp_clr = core_rst || warm_q;
    assign to_flag   = flags.to;
    assign pd_flag   = flags.pd;

    AST_WARM_SINGLE: assert property (@(posedge clk) disable iff (por)
        warm_rst |=> !warm_rst); // R5

    AST_WARM_NOT_FULL: assert property (@(posedge clk) disable iff (por)
        warm_rst |-> !core_rst); // R5

    AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (por)
        ext_low |=> (core_rst && cnt == '0)); // R2

    AST_RELEASE_TERMINAL: assert property (@(posedge clk) disable iff (por)
        $fell(sst_busy) |-> ($past(cnt) == TERM)); // R1

    AST_CAUSE_RESTARTS: assert property (@(posedge clk) disable iff (por)
        (cause != CAUSE_NONE) |=> (sst_busy && cnt == '0)); // R7

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (por)
        (core_rst && !done) |=> core_rst); // R7

    AST_WAKE_NO_RST: assert property (@(posedge clk) disable iff (por)
        (cause == CAUSE_WAKE) |=> (sst_busy && !core_rst && !warm_rst)); // R6
endmodule

// File: tb/test_wake_reset_seq.sv
module test_wake_reset_seq;

    typedef struct {
        int    when;
        bit    core;
        bit    warm;
        bit    busy;
        bit    to;
        bit    pd;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic ext_rst_n = 1'b1;
    logic wdt_timeout = 1'b0;
    logic halted = 1'b0;
    logic wake_req = 1'b0;
    logic halt_exec = 1'b0;
    logic core_rst, warm_rst, pc_sp_clr, sst_busy, to_flag, pd_flag;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wake_reset_seq i_wake_reset_seq (
        .clk         (clk),
        .por         (por),
        .ext_rst_n   (ext_rst_n),
        .wdt_timeout (wdt_timeout),
        .halted      (halted),
        .wake_req    (wake_req),
        .halt_exec   (halt_exec),
        .core_rst    (core_rst),
        .warm_rst    (warm_rst),
        .pc_sp_clr   (pc_sp_clr),
        .sst_busy    (sst_busy),
        .to_flag     (to_flag),
        .pd_flag     (pd_flag)
    );

    task automatic expect_at(input int when, input bit core, input bit warm,
                             input bit busy, input bit to, input bit pd,
                             input string tag);
        exp_t e;
        e.when = when; e.core = core; e.warm = warm; e.busy = busy;
        e.to = to; e.pd = pd; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: compares expected items against outputs at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].when <= cyc) begin
            exp_t e;
            bit   pcsp;
            e = sb.pop_front();
            pcsp = e.core | e.warm;
            n_checks++;
            if (e.when < cyc) begin
                n_fail++;
                $display("FAIL %s: item for cycle %0d missed at cycle %0d", e.tag, e.when, cyc);
            end else if ({core_rst, warm_rst, pc_sp_clr, sst_busy, to_flag, pd_flag} !==
                         {e.core, e.warm, pcsp, e.busy, e.to, e.pd}) begin
                n_fail++;
                $display("FAIL %s @%0d: core/warm/pcsp/busy/to/pd actual %b%b%b%b%b%b expected %b%b%b%b%b%b",
                         e.tag, cyc, core_rst, warm_rst, pc_sp_clr, sst_busy, to_flag, pd_flag,
                         e.core, e.warm, pcsp, e.busy, e.to, e.pd);
            end
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cyc >= 150000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end before 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        int m;
        // R1: power-up
        repeat (3) @(negedge clk);
        por = 1'b0; k = cyc;
        expect_at(k + 1,    1, 0, 1, 0, 0, "R1 reset state");
        expect_at(k + 1023, 1, 0, 1, 0, 0, "R1 still held");
        expect_at(k + 1024, 0, 0, 0, 0, 0, "R1 released");
        wait_to(k + 1030);

        // R4: watchdog while running, PD stays 0
        wdt_timeout = 1'b1; k = cyc;
        expect_at(k + 1,    1, 0, 1, 1, 0, "R4 full reset TO set");
        expect_at(k + 1024, 1, 0, 1, 1, 0, "R4 still held");
        expect_at(k + 1025, 0, 0, 0, 1, 0, "R4 released");
        @(negedge clk); wdt_timeout = 1'b0;
        wait_to(k + 1030);

        // R8: halt instruction
        halt_exec = 1'b1; k = cyc;
        expect_at(k + 1, 0, 0, 0, 0, 1, "R8 halt flags");
        @(negedge clk); halt_exec = 1'b0;
        wait_to(k + 4);

        // R6: wake while running is ignored
        wake_req = 1'b1; k = cyc;
        expect_at(k + 1, 0, 0, 0, 0, 1, "R6 wake ignored");
        @(negedge clk); wake_req = 1'b0;
        expect_at(k + 3, 0, 0, 0, 0, 1, "R6 wake ignored later");
        wait_to(k + 5);

        // R5: watchdog while halted -> warm reset
        halted = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b1; k = cyc;
        expect_at(k + 1,    0, 0, 1, 1, 1, "R5 warm delay start");
        expect_at(k + 1024, 0, 0, 1, 1, 1, "R5 delay running");
        expect_at(k + 1025, 0, 1, 0, 1, 1, "R5 warm strobe");
        expect_at(k + 1026, 0, 0, 0, 1, 1, "R5 strobe one cycle");
        @(negedge clk); wdt_timeout = 1'b0;
        wait_to(k + 1028);
        halted = 1'b0;
        @(negedge clk);

        // R2: external pin while running
        ext_rst_n = 1'b0; k = cyc;
        expect_at(k + 2, 0, 0, 0, 1, 1, "R2 sync latency");
        expect_at(k + 3, 1, 0, 1, 1, 1, "R2 reset flags kept");
        m = k + 40;
        expect_at(m + 1,    1, 0, 1, 1, 1, "R2 held while low");
        expect_at(m + 1025, 1, 0, 1, 1, 1, "R2 delay running");
        expect_at(m + 1026, 0, 0, 0, 1, 1, "R2 released");
        wait_to(m);
        ext_rst_n = 1'b1;
        wait_to(m + 1030);

        // R3: external pin while halted
        halted = 1'b1;
        @(negedge clk);
        ext_rst_n = 1'b0; k = cyc;
        expect_at(k + 3, 1, 0, 1, 0, 1, "R3 halted pin flags");
        wait_to(k + 5);
        halted = 1'b0;
        m = k + 20;
        expect_at(m + 1026, 0, 0, 0, 0, 1, "R3 released");
        wait_to(m);
        ext_rst_n = 1'b1;
        wait_to(m + 1030);

        // R6: wake from halt
        halted = 1'b1;
        @(negedge clk);
        wake_req = 1'b1; k = cyc;
        expect_at(k + 1,    0, 0, 1, 0, 1, "R6 wake delay");
        expect_at(k + 1024, 0, 0, 1, 0, 1, "R6 wake running");
        expect_at(k + 1025, 0, 0, 0, 0, 1, "R6 wake done");
        expect_at(k + 1026, 0, 0, 0, 0, 1, "R6 no strobe");
        @(negedge clk); wake_req = 1'b0;
        wait_to(k + 1028);
        halted = 1'b0;
        @(negedge clk);

        // R7: restart during delay, not downgraded
        wdt_timeout = 1'b1; k = cyc;
        expect_at(k + 1, 1, 0, 1, 1, 1, "R7 first cause");
        @(negedge clk); wdt_timeout = 1'b0;
        wait_to(k + 500);
        halted = 1'b1; wdt_timeout = 1'b1;
        expect_at(k + 1025, 1, 0, 1, 1, 1, "R7 restarted");
        expect_at(k + 1524, 1, 0, 1, 1, 1, "R7 still full");
        expect_at(k + 1525, 0, 0, 0, 1, 1, "R7 released");
        expect_at(k + 1526, 0, 0, 0, 1, 1, "R7 no warm strobe");
        @(negedge clk); wdt_timeout = 1'b0;
        wait_to(k + 1528);
        halted = 1'b0;
        @(negedge clk);

        // R1: power-up again clears flags
        por = 1'b1;
        @(negedge clk);
        por = 1'b0; k = cyc;
        expect_at(k + 1,    1, 0, 1, 0, 0, "R1 reapplied");
        expect_at(k + 1024, 0, 0, 0, 0, 0, "R1 reapplied release");
        wait_to(k + 1030);

        if (!finished) begin
            finished = 1'b1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                n_fail++;
                $display("FAIL %s: item for cycle %0d never compared", e.tag, e.when);
            end
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule